// File: doc/BRIEF.md
# Masked GPIO Port Controller

This block is a register-mapped general-purpose I/O port with up to 32 pins. Software reaches it through a simple word-select bus: a 4-bit register select, 32-bit write data with a write strobe, and a combinational read-data return. Software can choose each pin's direction and drive an output latch. The latch can be loaded whole, or it can have chosen bits set, cleared or toggled in a single write. A per-pin access mask screens every data access, meaning pin reads and all four kinds of latch write. The mask leaves the direction register and the interrupt registers alone.

Each pin can also act as an interrupt source. A pin can be set to latch edge events: rising only, falling only, or either edge. It can instead report a level, with the active level chosen per pin. Software can read the detected events (raw status) and the enabled events (masked status), and it clears latched events through a write-only clear register. A single interrupt line is the OR of all enabled events. A parameter sets how many pins exist. Register bits above that count read as zero and ignore writes.

Register select codes, all 32-bit: 0 pin read, 1 output latch, 2 set, 3 clear, 4 invert, 5 mask, 6 direction, 7 sense, 8 both-edge, 9 polarity, 10 interrupt enable, 11 raw status, 12 masked status, 13 interrupt clear. Codes 2, 3, 4 and 13 are write-only and read as zero. Codes 0, 11 and 12 are read-only.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, direction, output latch, sense, both-edge, polarity, enable and raw status are all zero. The mask holds ones on every implemented pin, and irq_o is 0.
- R2: Bit positions at or above NUM_PINS read as 0 in every register and ignore writes. The write-only registers (select 2, 3, 4, 13) read as 0.
- R3: The direction register (select 6) reads back what was written. Bit value 1 makes the pin an output, and pin_oe equals the register. The mask has no effect on writes to it.
- R4: A write to the output latch (select 1) loads only the bits whose mask bit is 1. Every other latch bit keeps its value, and pin_o shows the latch.
- R5: A write to select 2 sets the latch bits where the data is 1 and the mask is 1. A write to select 3 clears those bits. All other bits are unchanged.
- R6: A write to select 4 toggles the latch bits where the data is 1 and the mask is 1. All other bits are unchanged.
- R7: The pin-read register (select 0) returns the pad input after a two-flop synchroniser, ANDed with the mask. A pad change is visible after the second rising clock edge, and pins set as outputs also read their pad.
- R8: With sense bit 0, a pin latches a raw-status bit on a synchronised edge. With both-edge 1 it latches on either edge. Otherwise it latches on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The bit holds until a 1 is written to its position in select 13.
- R9: With sense bit 1, the raw-status bit equals 1 while the synchronised pin matches the polarity bit (1 means high). Writing the clear register does not remove it while the level stays active.
- R10: Masked status (select 12) equals raw status ANDed with the enable register, and irq_o is 1 exactly when masked status is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register select |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register (combinational) |
| pin_i | input | NUM_PINS | Pad input levels |
| pin_o | output | NUM_PINS | Output latch to the pad drivers |
| pin_oe | output | NUM_PINS | Output enable per pin (1 = drive) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The latch operations are exercised with masks of all ones, low byte only and alternating nibbles. Each data value differs in every nibble, so a mask that is ignored, inverted or applied to the wrong operation gives a different word. Pin reads are sampled one edge and then two edges after a pad change, which exposes a missing or extra synchroniser stage. The interrupt tests run three pins side by side, one rising-only, one falling-only and one both-edge, through a rise and then a fall, which separates polarity errors from both-edge errors. Level-sensed pins of both polarities are then cleared while still active, which shows whether the clear register wrongly overrides a live level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int REG_W = 32;
   localparam int SEL_W = 4;

   typedef enum logic [SEL_W-1:0] {
      SEL_PIN   = 4'd0,
      SEL_OUT   = 4'd1,
      SEL_SET   = 4'd2,
      SEL_CLR   = 4'd3,
      SEL_INV   = 4'd4,
      SEL_MASK  = 4'd5,
      SEL_DIR   = 4'd6,
      SEL_SENSE = 4'd7,
      SEL_BOTH  = 4'd8,
      SEL_POL   = 4'd9,
      SEL_IEN   = 4'd10,
      SEL_RAW   = 4'd11,
      SEL_MSTAT = 4'd12,
      SEL_ICLR  = 4'd13
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_load,
   input  logic         we_set,
   input  logic         we_clr,
   input  logic         we_tgl,
   input  logic [W-1:0] d,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);
   logic [W-1:0] sel_bits;
   logic [W-1:0] q_next;

   assign sel_bits = d & mask;

   always_comb begin
      q_next = q;
      if (we_load)     q_next = (q & ~mask) | sel_bits;
      else if (we_set) q_next = q | sel_bits;
      else if (we_clr) q_next = q & ~sel_bits;
      else if (we_tgl) q_next = q ^ sel_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
   end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_s,
   input  logic [W-1:0] sense,
   input  logic [W-1:0] both,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] ien,
   input  logic         clr_we,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] raw,
   output logic [W-1:0] mstat,
   output logic         irq
);
   logic [W-1:0] pin_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= '0;
      else        pin_d <= pin_s;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall, hit, edge_q;

      assign rise = pin_s[i] & ~pin_d[i];
      assign fall = ~pin_s[i] & pin_d[i];
      assign hit  = ~sense[i] & (both[i] ? (rise | fall) : (pol[i] ? rise : fall));

      // a new event wins over a clear arriving in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     edge_q <= 1'b0;
         else if (hit)                   edge_q <= 1'b1;
         else if (clr_we && clr_bits[i]) edge_q <= 1'b0;
      end

      assign raw[i] = sense[i] ? (pin_s[i] ~^ pol[i]) : edge_q;
   end

   assign mstat = raw & ien;
   assign irq   = |mstat;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEL_W-1:0]     addr,
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rd_data,
   input  logic [NUM_PINS-1:0]  pin_i,
   output logic [NUM_PINS-1:0]  pin_o,
   output logic [NUM_PINS-1:0]  pin_oe,
   output logic                 irq_o
);
   localparam int PAD_W = REG_W - NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > REG_W) begin : g_bad_pins
      $error("gpio_port_ctrl: NUM_PINS must be 1 to 32");
   end

   logic [NUM_PINS-1:0] wd;
   logic [NUM_PINS-1:0] mask_q, dir_q, sense_q, both_q, pol_q, ien_q;
   logic [NUM_PINS-1:0] pin_s, raw, mstat;
   logic [NUM_PINS-1:0] rd_core;
   logic we_out, we_set, we_clr, we_inv, we_mask, we_dir;
   logic we_sense, we_both, we_pol, we_ien, we_iclr;

   assign wd = wdata[NUM_PINS-1:0];

   assign we_out   = wr_en && (addr == SEL_OUT);
   assign we_set   = wr_en && (addr == SEL_SET);
   assign we_clr   = wr_en && (addr == SEL_CLR);
   assign we_inv   = wr_en && (addr == SEL_INV);
   assign we_mask  = wr_en && (addr == SEL_MASK);
   assign we_dir   = wr_en && (addr == SEL_DIR);
   assign we_sense = wr_en && (addr == SEL_SENSE);
   assign we_both  = wr_en && (addr == SEL_BOTH);
   assign we_pol   = wr_en && (addr == SEL_POL);
   assign we_ien   = wr_en && (addr == SEL_IEN);
   assign we_iclr  = wr_en && (addr == SEL_ICLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         dir_q   <= '0;
         sense_q <= '0;
         both_q  <= '0;
         pol_q   <= '0;
         ien_q   <= '0;
      end else begin
         if (we_mask)  mask_q  <= wd;
         if (we_dir)   dir_q   <= wd;
         if (we_sense) sense_q <= wd;
         if (we_both)  both_q  <= wd;
         if (we_pol)   pol_q   <= wd;
         if (we_ien)   ien_q   <= wd;
      end
   end

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_i),
      .q     (pin_s)
   );

   gpio_out_latch #(.W(NUM_PINS)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_load (we_out),
      .we_set  (we_set),
      .we_clr  (we_clr),
      .we_tgl  (we_inv),
      .d       (wd),
      .mask    (mask_q),
      .q       (pin_o)
   );

   gpio_irq_unit #(.W(NUM_PINS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s    (pin_s),
      .sense    (sense_q),
      .both     (both_q),
      .pol      (pol_q),
      .ien      (ien_q),
      .clr_we   (we_iclr),
      .clr_bits (wd),
      .raw      (raw),
      .mstat    (mstat),
      .irq      (irq_o)
   );

   assign pin_oe = dir_q;

   always_comb begin
      unique case (addr)
         SEL_PIN:   rd_core = pin_s & mask_q;
         SEL_OUT:   rd_core = pin_o;
         SEL_MASK:  rd_core = mask_q;
         SEL_DIR:   rd_core = dir_q;
         SEL_SENSE: rd_core = sense_q;
         SEL_BOTH:  rd_core = both_q;
         SEL_POL:   rd_core = pol_q;
         SEL_IEN:   rd_core = ien_q;
         SEL_RAW:   rd_core = raw;
         SEL_MSTAT: rd_core = mstat;
         default:   rd_core = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, rd_core};
   end else begin : g_full
      assign rd_data = rd_core;
   end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
   import gpio_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SEL_W-1:0]    addr,
   input logic                wr_en,
   input logic [REG_W-1:0]    wdata,
   input logic [NUM_PINS-1:0] pin_o,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq_o,
   input logic [NUM_PINS-1:0] mask_q,
   input logic [NUM_PINS-1:0] ien_q
);
   logic [NUM_PINS-1:0] wsel;
   logic out_grp_wr;

   assign wsel       = wdata[NUM_PINS-1:0] & mask_q;
   assign out_grp_wr = wr_en && (addr == SEL_OUT || addr == SEL_SET ||
                                 addr == SEL_CLR || addr == SEL_INV);

   assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == SEL_DIR) |=> $stable(pin_oe));

   assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_grp_wr |=> $stable(pin_o));

   assert_masked_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_grp_wr |=> ((pin_o & ~$past(mask_q)) == ($past(pin_o) & ~$past(mask_q))));

   assert_set_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == SEL_SET) |=> ((pin_o & $past(wsel)) == $past(wsel)));

   assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == SEL_CLR) |=> ((pin_o & $past(wsel)) == '0));

   assert_inv_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == SEL_INV) |=> ((pin_o ^ $past(pin_o)) == $past(wsel)));

   assert_irq_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ien_q != '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (addr),
   .wr_en  (wr_en),
   .wdata  (wdata),
   .pin_o  (pin_o),
   .pin_oe (pin_oe),
   .irq_o  (irq_o),
   .mask_q (mask_q),
   .ien_q  (ien_q)
);

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    addr = '0;
   logic          wr_en = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rd_data;
   logic [N-1:0]  pin_i = '0;
   logic [N-1:0]  pin_o;
   logic [N-1:0]  pin_oe;
   logic          irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   gpio_port_ctrl #(.NUM_PINS(N)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_data(rd_data), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
      .irq_o(irq_o)
   );

   localparam logic [3:0] A_PIN = 4'd0, A_OUT = 4'd1, A_SET = 4'd2, A_CLR = 4'd3,
      A_INV = 4'd4, A_MASK = 4'd5, A_DIR = 4'd6, A_SENSE = 4'd7, A_BOTH = 4'd8,
      A_POL = 4'd9, A_IEN = 4'd10, A_RAW = 4'd11, A_MST = 4'd12, A_ICLR = 4'd13;

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(A_DIR, v);  check("R1 dir", v, 32'h0);
      rd(A_OUT, v);  check("R1 out", v, 32'h0);
      rd(A_MASK, v); check("R1 mask", v, 32'h0000_FFFF);
      rd(A_IEN, v);  check("R1 ien", v, 32'h0);
      rd(A_RAW, v);  check("R1 raw", v, 32'h0);
      check("R1 oe", {16'h0, pin_oe}, 32'h0);
      check("R1 irq", {31'h0, irq_o}, 32'h0);
   endtask

   task automatic t_dir;
      logic [31:0] v;
      wr(A_DIR, 32'hFFFF_00F0);
      rd(A_DIR, v);  check("R2 dir upper bits", v, 32'h0000_00F0);
      check("R3 pin_oe", {16'h0, pin_oe}, 32'h0000_00F0);
      wr(A_MASK, 32'h0);
      wr(A_DIR, 32'h0000_A5A5);
      rd(A_DIR, v);  check("R3 dir ignores mask", v, 32'h0000_A5A5);
      wr(A_MASK, 32'hFFFF_FFFF);
      rd(A_MASK, v); check("R2 mask upper bits", v, 32'h0000_FFFF);
   endtask

   task automatic t_out;
      logic [31:0] v;
      wr(A_OUT, 32'h0000_1234);
      check("R4 full mask load", {16'h0, pin_o}, 32'h0000_1234);
      wr(A_MASK, 32'h0000_00FF);
      wr(A_OUT, 32'h0000_ABCD);
      rd(A_OUT, v);  check("R4 masked load", v, 32'h0000_12CD);
   endtask

   task automatic t_setclr;
      logic [31:0] v;
      wr(A_SET, 32'h0000_FFFF);
      check("R5 masked set", {16'h0, pin_o}, 32'h0000_12FF);
      wr(A_CLR, 32'h0000_0F0F);
      check("R5 masked clear", {16'h0, pin_o}, 32'h0000_12F0);
      wr(A_MASK, 32'h0000_FFFF);
      wr(A_CLR, 32'h0000_FFFF);
      wr(A_SET, 32'h0000_8001);
      check("R5 set after clear", {16'h0, pin_o}, 32'h0000_8001);
      rd(A_SET, v);  check("R2 set reads zero", v, 32'h0);
   endtask

   task automatic t_inv;
      logic [31:0] v;
      wr(A_MASK, 32'h0000_0F0F);
      wr(A_INV, 32'h0000_FFFF);
      rd(A_OUT, v);  check("R6 masked toggle", v, 32'h0000_8F0E);
      rd(A_INV, v);  check("R2 invert reads zero", v, 32'h0);
      wr(A_MASK, 32'h0000_FFFF);
   endtask

   task automatic t_pinread;
      logic [31:0] v;
      @(negedge clk);
      addr = A_PIN; pin_i = 16'h3C5A;
      @(posedge clk); #1 check("R7 one edge still old", rd_data, 32'h0);
      @(posedge clk); #1 check("R7 two edges visible", rd_data, 32'h0000_3C5A);
      wr(A_MASK, 32'h0000_00FF);
      rd(A_PIN, v);  check("R7 masked read, output pins read pad", v, 32'h0000_005A);
      wr(A_MASK, 32'h0000_FFFF);
      @(negedge clk); pin_i = '0;
      settle(4);
   endtask

   task automatic t_edge;
      logic [31:0] v;
      wr(A_ICLR, 32'h0000_FFFF);
      rd(A_RAW, v);  check("R8 clear all", v, 32'h0);
      wr(A_POL, 32'h0000_0001);
      wr(A_BOTH, 32'h0000_0004);
      wr(A_IEN, 32'h0000_0007);
      @(negedge clk); pin_i = 16'h0007;
      settle(4);
      rd(A_RAW, v);  check("R8 rise: rising and both-edge pins", v, 32'h0000_0005);
      rd(A_MST, v);  check("R10 masked status", v, 32'h0000_0005);
      check("R10 irq high", {31'h0, irq_o}, 32'h1);
      @(negedge clk); pin_i = '0;
      settle(4);
      rd(A_RAW, v);  check("R8 fall adds falling pin, rise latched", v, 32'h0000_0007);
      wr(A_ICLR, 32'h0000_0001);
      rd(A_RAW, v);  check("R8 selective clear", v, 32'h0000_0006);
      wr(A_IEN, 32'h0000_0002);
      rd(A_MST, v);  check("R10 enable gating", v, 32'h0000_0002);
      wr(A_ICLR, 32'h0000_FFFF);
      check("R10 irq low after clear", {31'h0, irq_o}, 32'h0);
   endtask

   task automatic t_level;
      logic [31:0] v;
      wr(A_IEN, 32'h0);
      wr(A_POL, 32'h0000_0010);
      wr(A_SENSE, 32'h0000_0030);
      rd(A_RAW, v);  check("R9 active-low level while low", v, 32'h0000_0020);
      wr(A_IEN, 32'h0000_0010);
      check("R10 irq off when only disabled active", {31'h0, irq_o}, 32'h0);
      @(negedge clk); pin_i = 16'h0010;
      settle(4);
      rd(A_RAW, v);  check("R9 active-high level", v, 32'h0000_0030);
      wr(A_ICLR, 32'h0000_0030);
      rd(A_RAW, v);  check("R9 clear does not remove live level", v, 32'h0000_0030);
      check("R10 irq from level", {31'h0, irq_o}, 32'h1);
      @(negedge clk); pin_i = '0;
      settle(4);
      rd(A_RAW, v);  check("R9 level released", v, 32'h0000_0020);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      settle(3);
      rst_n = 1'b1;
      settle(2);
      t_reset;
      t_dir;
      t_out;
      t_setclr;
      t_inv;
      t_pinread;
      t_edge;
      t_level;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule